// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of a successive-approximation analog-to-digital converter. After a start pulse it drives a trial code to an external DAC. Each clock it samples a one-bit comparator that reports whether the held analog input is at or above the DAC level, and it settles one bit of the code per cycle, starting from the most significant bit. The DAC, the comparator and the sample-and-hold sit outside the block and appear only as ports.

When the last bit has been settled, the finished code is copied into a holding register and a one-cycle done strobe is raised. The holding register keeps that code while the next conversion runs, so a consumer can read it at any time until the next done strobe. Each bit is also sent out serially as soon as it is settled, most significant first, with a qualifying valid flag. The resolution `WIDTH` is a parameter. The serial port can be removed with `SERIAL_EN`.

Top module: `sar_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `trial_o` and `result_o` to zero and drives `busy_o`, `done_o`, `ser_valid_o` and `ser_bit_o` low.
- R2: A `start_i` sampled high while idle is accepted at that edge. In the next cycle `trial_o` has only bit WIDTH-1 set and `busy_o` is high.
- R3: At each decision edge the bit under test is cleared if `cmp_above_i` is 0, meaning the input is below the DAC level, and kept at 1 if it is 1. If that bit was not bit 0, the next lower bit is set to 1. Bits already decided do not change.
- R4: `done_o` rises exactly WIDTH clock edges after the edge that accepted the start, whatever the input level.
- R5: `busy_o` stays high from the cycle after the accepting edge until the cycle in which `done_o` is high, where it is low. A `start_i` seen while busy is ignored and does not restart or lengthen the conversion.
- R6: `done_o` is high for exactly one cycle. `result_o` takes the final code at the same edge that raises `done_o`.
- R7: `result_o` changes only at an edge that raises `done_o`. It holds the previous code throughout a following conversion.
- R8: With `SERIAL_EN`=1, `ser_valid_o` is high in the cycle after each decision edge, and `ser_bit_o` then carries the bit just decided (1 = kept). The bits come most significant first, and the last one coincides with `done_o`.
- R9: With WIDTH=8 and the analog input at 0.2 of full scale (51.2 LSB), the result is 8'b00110011. Inputs at 0, at full scale minus 0.1 LSB, at exactly 128 LSB and at 127.9 LSB give 0, 255, 128 and 127.
- R10: While idle, `trial_o` is zero and the comparator input has no effect on any output.
- R11: A `start_i` high during the cycle in which `done_o` is high is accepted, so conversions can run back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_above_i | input | 1 | Comparator: 1 = input at or above trial level |
| trial_o | output | WIDTH | Trial code to the external DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | WIDTH | Holding register with the last finished code |
| ser_bit_o | output | 1 | Most recently decided bit |
| ser_valid_o | output | 1 | Qualifies `ser_bit_o` |

## Verification
The key overlap is the done cycle. In that cycle the holding register loads, the final serial bit is presented and a new start may be accepted, all at once. The bench raises `start_i` exactly while `done_o` is high. It then judges three things: the new conversion begins with the MSB-only trial on the next cycle, the serial stream assembled up to and including the done cycle equals the loaded result, and `result_o` keeps the old code for all of the chained conversion until its own done. A second collision, a start pulse in the middle of a conversion, is provoked and judged by the unchanged decision count and trial sequence against the reference model.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

   typedef enum logic [0:0] {
      SAR_IDLE = 1'b0,
      SAR_CONV = 1'b1
   } sar_state_e;

endpackage

// File: rtl/sar_ctrl_seq.sv
module sar_ctrl_seq
   import sar_ctrl_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   output sar_state_e       state_o,
   output logic [WIDTH-1:0] mask_o,
   output logic             accept_o,
   output logic             decide_o,
   output logic             last_o
);

   localparam logic [WIDTH-1:0] TOP_MASK = {1'b1, {(WIDTH-1){1'b0}}};

   sar_state_e       state_q;
   logic [WIDTH-1:0] mask_q;

   assign accept_o = (state_q == SAR_IDLE) && start_i;
   assign decide_o = (state_q == SAR_CONV);
   assign last_o   = decide_o && mask_q[0];

   // One-hot pointer to the bit under test walks from MSB to LSB.
   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SAR_IDLE;
         mask_q  <= '0;
      end else if (accept_o) begin
         state_q <= SAR_CONV;
         mask_q  <= TOP_MASK;
      end else if (decide_o) begin
         mask_q <= mask_q >> 1;
         if (last_o) begin
            state_q <= SAR_IDLE;
         end
      end
   end

   assign state_o = state_q;
   assign mask_o  = mask_q;

endmodule

// File: rtl/sar_ctrl_trial.sv
module sar_ctrl_trial #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept_i,
   input  logic             decide_i,
   input  logic             last_i,
   input  logic [WIDTH-1:0] mask_i,
   input  logic             cmp_i,
   output logic [WIDTH-1:0] trial_o,
   output logic [WIDTH-1:0] code_o
);

   logic [WIDTH-1:0] trial_q;
   logic [WIDTH-1:0] next_mask;

   assign next_mask = mask_i >> 1;

   // Code with the bit under test already resolved.
   assign code_o = (trial_q & ~mask_i) | (mask_i & {WIDTH{cmp_i}});

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      localparam logic IS_TOP = (i == WIDTH - 1);
      always_ff @(posedge clk) begin
         if (rst) begin
            trial_q[i] <= 1'b0;
         end else if (accept_i) begin
            trial_q[i] <= IS_TOP;
         end else if (last_i) begin
            trial_q[i] <= 1'b0;
         end else if (decide_i) begin
            if (mask_i[i]) begin
               trial_q[i] <= cmp_i;
            end else if (next_mask[i]) begin
               trial_q[i] <= 1'b1;
            end
         end
      end
   end

   assign trial_o = trial_q;

endmodule

// File: rtl/sar_ctrl_out.sv
module sar_ctrl_out #(
   parameter int WIDTH     = 8,
   parameter bit SERIAL_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             decide_i,
   input  logic             last_i,
   input  logic             cmp_i,
   input  logic [WIDTH-1:0] code_i,
   output logic [WIDTH-1:0] result_o,
   output logic             done_o,
   output logic             ser_bit_o,
   output logic             ser_valid_o
);

   logic [WIDTH-1:0] result_q;
   logic             done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         result_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= last_i;
         if (last_i) begin
            result_q <= code_i;
         end
      end
   end

   assign result_o = result_q;
   assign done_o   = done_q;

   if (SERIAL_EN) begin : g_serial
      logic bit_q;
      logic valid_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            bit_q   <= 1'b0;
            valid_q <= 1'b0;
         end else begin
            valid_q <= decide_i;
            bit_q   <= decide_i & cmp_i;
         end
      end
      assign ser_bit_o   = bit_q;
      assign ser_valid_o = valid_q;
   end else begin : g_no_serial
      logic unused_serial;
      assign unused_serial = decide_i ^ cmp_i;
      assign ser_bit_o     = 1'b0;
      assign ser_valid_o   = 1'b0;
   end

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
   import sar_ctrl_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter bit SERIAL_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             cmp_above_i,
   output logic [WIDTH-1:0] trial_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [WIDTH-1:0] result_o,
   output logic             ser_bit_o,
   output logic             ser_valid_o
);

   initial begin : p_param_check
      if (WIDTH < 2 || WIDTH > 24) begin
         $fatal(1, "sar_ctrl: WIDTH must lie in 2..24");
      end
   end

   sar_state_e       state;
   logic [WIDTH-1:0] mask;
   logic             accept;
   logic             decide;
   logic             last;
   logic [WIDTH-1:0] code;

   sar_ctrl_seq #(.WIDTH(WIDTH)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .start_i  (start_i),
      .state_o  (state),
      .mask_o   (mask),
      .accept_o (accept),
      .decide_o (decide),
      .last_o   (last)
   );

   sar_ctrl_trial #(.WIDTH(WIDTH)) u_trial (
      .clk      (clk),
      .rst      (rst),
      .accept_i (accept),
      .decide_i (decide),
      .last_i   (last),
      .mask_i   (mask),
      .cmp_i    (cmp_above_i),
      .trial_o  (trial_o),
      .code_o   (code)
   );

   sar_ctrl_out #(.WIDTH(WIDTH), .SERIAL_EN(SERIAL_EN)) u_out (
      .clk         (clk),
      .rst         (rst),
      .decide_i    (decide),
      .last_i      (last),
      .cmp_i       (cmp_above_i),
      .code_i      (code),
      .result_o    (result_o),
      .done_o      (done_o),
      .ser_bit_o   (ser_bit_o),
      .ser_valid_o (ser_valid_o)
   );

   assign busy_o = (state == SAR_CONV);

endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             start_i,
   input logic [WIDTH-1:0] trial_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [WIDTH-1:0] result_o,
   input logic             ser_valid_o
);

   localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

   logic seen;
   always_ff @(posedge clk) begin
      if (rst) seen <= 1'b0;
      else     seen <= 1'b1;
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (trial_o == '0 && result_o == '0 && !busy_o && !done_o && !ser_valid_o)); // R1

   AST_START_LOADS_TOP: assert property (@(posedge clk) disable iff (rst)
      (!busy_o && start_i) |=> (busy_o && trial_o == TOP_ONLY)); // R2

   AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
      (seen && busy_o && $past(busy_o)) |-> (trial_o != TOP_ONLY)); // R5

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
      (seen && done_o) |-> (!busy_o && $past(busy_o))); // R5

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o); // R6

   AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (seen && !done_o) |-> (result_o == $past(result_o))); // R7

   AST_SERIAL_IN_CONV: assert property (@(posedge clk) disable iff (rst)
      (seen && ser_valid_o) |-> $past(busy_o)); // R8

   AST_IDLE_TRIAL_ZERO: assert property (@(posedge clk) disable iff (rst)
      !busy_o |-> (trial_o == '0)); // R10

endmodule

bind sar_ctrl sar_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .start_i     (start_i),
   .trial_o     (trial_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .result_o    (result_o),
   .ser_valid_o (ser_valid_o)
);

// File: tb/sar_ctrl_bench.sv
`timescale 1ns/1ps
module sar_ctrl_bench;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   int           vin10 = 0;   // analog input in tenths of an LSB
   logic         cmp;
   logic [W-1:0] trial;
   logic         busy;
   logic         done;
   logic [W-1:0] result;
   logic         ser_bit;
   logic         ser_valid;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit started = 1'b0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   // External comparator model: 1 when the input is at or above the DAC level.
   assign cmp = (vin10 >= int'(trial) * 10);

   sar_ctrl #(.WIDTH(W), .SERIAL_EN(1'b1)) u_sar_ctrl (
      .clk         (clk),
      .rst         (rst),
      .start_i     (start),
      .cmp_above_i (cmp),
      .trial_o     (trial),
      .busy_o      (busy),
      .done_o      (done),
      .result_o    (result),
      .ser_bit_o   (ser_bit),
      .ser_valid_o (ser_valid)
   );

   // Behavioural reference model.
   int m_trial = 0, m_result = 0, m_bitpos = 0;
   bit m_busy = 0, m_done = 0, m_ser = 0, m_sv = 0;

   always @(posedge clk) begin
      started <= 1'b1;
      if (rst) begin
         m_trial = 0; m_result = 0; m_busy = 0; m_done = 0; m_ser = 0; m_sv = 0;
      end else begin
         m_done = 0; m_sv = 0; m_ser = 0;
         if (!m_busy) begin
            if (start) begin
               m_busy = 1; m_bitpos = W - 1; m_trial = 1 << (W - 1);
            end
         end else begin
            bit keep;
            keep = (vin10 >= m_trial * 10);
            if (!keep) m_trial = m_trial - (1 << m_bitpos);
            m_ser = keep; m_sv = 1;
            if (m_bitpos == 0) begin
               m_result = m_trial; m_done = 1; m_busy = 0; m_trial = 0;
            end else begin
               m_bitpos = m_bitpos - 1;
               m_trial = m_trial + (1 << m_bitpos);
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Per-cycle comparison against the model, away from the active edge.
   always @(negedge clk) begin
      if (started && !finished) begin
         check(int'(trial) == m_trial, "R3", "trial_o model", int'(trial), m_trial);
         check(busy == m_busy, "R5", "busy_o model", busy, m_busy);
         check(done == m_done, "R6", "done_o model", done, m_done);
         check(int'(result) == m_result, "R7", "result_o model", int'(result), m_result);
         check(ser_valid == m_sv && ser_bit == m_ser, "R8", "serial model",
               {ser_valid, ser_bit}, {m_sv, m_ser});
      end
   end

   task automatic summary();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         failures++;
         $display("FAIL R4 watchdog cycles=%0d expected=below 20000", cyc);
         summary();
      end
   end

   // Call at a negedge; returns at the negedge where done_o is high.
   task automatic run_conv(input int v, output int ndec, output int res, output int ser);
      vin10 = v;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(int'(trial) == (1 << (W - 1)) && busy, "R2", "first trial", int'(trial), 1 << (W - 1));
      ndec = 0; ser = 0;
      while (!done && ndec < 4 * W) begin
         @(negedge clk);
         ndec++;
         if (ser_valid) ser = (ser << 1) | int'(ser_bit);
      end
      res = int'(result);
   endtask

   initial begin
      int nd, res, ser, held;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check(trial == '0 && result == '0 && !busy && !done && !ser_valid, "R1",
            "reset state", int'(trial) + int'(result), 0);

      // Worked example: 0.2 of full scale.
      @(negedge clk);
      run_conv(512, nd, res, ser);
      check(nd == W, "R4", "decision count", nd, W);
      check(res == 8'h33, "R9", "0.2 FS result", res, 8'h33);
      check(ser == res, "R8", "serial stream", ser, res);
      check(!busy, "R5", "busy low with done", busy, 0);
      @(negedge clk);
      check(!done, "R6", "done one cycle", done, 0);

      // Boundary levels.
      @(negedge clk); run_conv(0, nd, res, ser);
      check(res == 0, "R9", "zero input", res, 0);
      check(nd == W, "R4", "decision count zero", nd, W);
      @(negedge clk); run_conv(2559, nd, res, ser);
      check(res == 255, "R9", "full scale", res, 255);
      check(ser == 255, "R8", "serial full", ser, 255);
      @(negedge clk); run_conv(1280, nd, res, ser);
      check(res == 128, "R3", "exact level kept", res, 128);
      @(negedge clk); run_conv(1279, nd, res, ser);
      check(res == 127, "R3", "just below level", res, 127);

      // Comparator toggling while idle has no effect.
      held = int'(result);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         vin10 = (k % 2) ? 2559 : 0;
      end
      @(negedge clk);
      check(trial == '0 && !busy && !done, "R10", "idle trial", int'(trial), 0);
      check(int'(result) == held, "R10", "idle result", int'(result), held);

      // Start pulse in the middle of a conversion is ignored.
      @(negedge clk);
      vin10 = 1000; start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk); @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      nd = 3;
      while (!done && nd < 4 * W) begin
         @(negedge clk);
         nd++;
      end
      check(nd == W, "R5", "start while busy", nd, W);
      check(int'(result) == 100, "R5", "result after ignored start", int'(result), 100);

      // Back-to-back: start raised during the done cycle.
      held = int'(result);
      vin10 = 1800; start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy && int'(trial) == (1 << (W - 1)), "R11", "chained start", int'(trial), 1 << (W - 1));
      nd = 0;
      while (!done && nd < 4 * W) begin
         check(int'(result) == held, "R7", "result held", int'(result), held);
         @(negedge clk);
         nd++;
      end
      check(nd == W, "R11", "chained length", nd, W);
      check(int'(result) == 180, "R6", "chained result", int'(result), 180);

      // Reset in mid-conversion.
      @(negedge clk);
      vin10 = 700; start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk); @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(trial == '0 && result == '0 && !busy && !ser_valid, "R1", "mid reset",
            int'(trial) + int'(result), 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      summary();
   end

endmodule